// File: doc/BRIEF.md
# Colour Palette Index and Data Port

This block is the host-facing register front end of a colour lookup table. The host sees four byte-wide register addresses: a write-pointer register, a read-pointer register, a shared data register and one aliased control register. A table entry is 24 bits wide. The host moves it as three back-to-back byte accesses to the data register, red first, then green, then blue. A write is staged until its blue byte arrives, and the whole entry is then stored in one step. After the third byte of an entry, the relevant pointer moves to the next entry. A software-controlled mode input redirects data accesses to a small cursor palette, and in that mode the pointers stay where they are.

The same mode input also decides what the aliased control register holds. With the mode input low it is the pixel mask, which is ANDed into every display index. With the mode input high it is the converter command byte, which is presented on an output. On the display side, an index is looked up in the table after masking. A separate cursor select picks one cursor colour. Both results appear one clock later.

Top module: `pal_dac_port`

## Requirements
- R1: After reset the colour phase is red, both pointers are 0, the pixel mask is 0xFF, the command byte is 0x00, and `host_rdata`, `pix_rgb` and `cur_rgb` are 0.
- R2: A write to address 2 loads the write pointer. A write to address 1 loads the read pointer. Either write restarts the colour phase at red. Reading address 2 returns the write pointer and reading address 1 returns the read pointer, one cycle after the read strobe.
- R3: Data writes (address 3) are taken as red, green, blue in that order. The red and green bytes are only staged. The entry is stored when the blue byte is written, so before that the display port still shows the old colour.
- R4: In main-palette mode (`cur_mode`=0) the write pointer increments after each blue write and wraps from the last entry to 0.
- R5: In main-palette mode, data reads (address 3) return the red, green and blue bytes of the read-pointer entry in that order on `host_rdata`, one cycle after each strobe. The read pointer then increments.
- R6: With `cur_mode`=1, data accesses use cursor colour number (pointer bit 0) and leave the main table unchanged.
- R7: With `cur_mode`=1 neither pointer changes after the third data access. A second triple goes to the same cursor colour.
- R8: Address 0 is the pixel mask when `cur_mode`=0 and the command byte when `cur_mode`=1. Reads and writes both follow this selection. A write to one leaves the other unchanged. The command byte drives `dac_ctl`.
- R9: `pix_rgb` shows the entry at (`pix_idx` AND mask) one cycle after `pix_idx` is applied, with red in bits 23:16, green in 15:8 and blue in 7:0. `cur_rgb` shows cursor colour `cur_pick` one cycle later in the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_mode | input | 1 | 1 selects the cursor palette and the command register |
| host_wr | input | 1 | Host write strobe, takes precedence over read |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | 0 mask/command, 1 read pointer, 2 write pointer, 3 data |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| pix_idx | input | IDX_W (8) | Display index |
| pix_rgb | output | 24 | Display colour |
| cur_pick | input | CUR_W (1) | Cursor colour select |
| cur_rgb | output | 24 | Cursor colour |
| dac_ctl | output | 8 | Command byte to the converter |

## Verification
Complete triples at several entries establish the basic store and fetch. An interrupted triple, checked on the display port after only red and green, shows whether an entry is committed before its blue byte. Writing 0xFF and then continuing reveals how the pointer wraps. Reloading a pointer partway through a triple shows whether the phase restarts. The cursor-mode sequences repeat triples without reloading the pointer and probe the main table afterwards, which separates "no increment" from "wrong target". Writes to the aliased address in each mode, followed by masked lookups, show whether mask and command are kept apart.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;
   localparam int COMP_W = 8;

   typedef logic [COMP_W-1:0] comp_t;

   typedef struct packed {
      comp_t r;
      comp_t g;
      comp_t b;
   } rgb_t;

   typedef enum logic [1:0] {
      PH_RED = 2'd0,
      PH_GRN = 2'd1,
      PH_BLU = 2'd2
   } phase_e;

   localparam logic [1:0] A_MASKCMD = 2'd0;
   localparam logic [1:0] A_RIDX    = 2'd1;
   localparam logic [1:0] A_WIDX    = 2'd2;
   localparam logic [1:0] A_DATA    = 2'd3;
endpackage

// File: rtl/pal_dac_seq.sv
module pal_dac_seq
   import pal_dac_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cur_mode,
   input  logic             ld_widx,
   input  logic             ld_ridx,
   input  logic             dat_wr,
   input  logic             dat_rd,
   input  logic [IDX_W-1:0] ld_val,
   output phase_e           phase,
   output logic [IDX_W-1:0] wr_ptr,
   output logic [IDX_W-1:0] rd_ptr,
   output logic             commit
);
   logic   last;
   phase_e phase_nx;

   assign last   = (phase == PH_BLU);
   assign commit = dat_wr & last;

   always_comb begin
      case (phase)
         PH_RED:  phase_nx = PH_GRN;
         PH_GRN:  phase_nx = PH_BLU;
         default: phase_nx = PH_RED;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase  <= PH_RED;
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (ld_widx || ld_ridx)
            phase <= PH_RED;
         else if (dat_wr || dat_rd)
            phase <= phase_nx;

         if (ld_widx)
            wr_ptr <= ld_val;
         else if (commit && !cur_mode)
            wr_ptr <= wr_ptr + 1'b1;

         if (ld_ridx)
            rd_ptr <= ld_val;
         else if (dat_rd && last && !cur_mode)
            rd_ptr <= rd_ptr + 1'b1;
      end
   end
endmodule

// File: rtl/pal_dac_store.sv
module pal_dac_store
   import pal_dac_pkg::*;
#(
   parameter int IDX_W   = 8,
   parameter int CUR_N   = 2,
   parameter int CUR_W   = $clog2(CUR_N),
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cur_mode,
   input  logic             dat_wr,
   input  logic             commit,
   input  phase_e           phase,
   input  comp_t            wdata,
   input  logic [IDX_W-1:0] wr_ptr,
   input  logic [IDX_W-1:0] rd_ptr,
   input  logic [IDX_W-1:0] look_idx,
   input  logic [CUR_W-1:0] cur_pick,
   output comp_t            host_byte,
   output rgb_t             pix_rgb,
   output rgb_t             cur_rgb
);
   localparam int ENTRIES = 1 << IDX_W;

   comp_t stage_r, stage_g;
   rgb_t  tbl     [ENTRIES];
   rgb_t  cur_tbl [CUR_N];
   rgb_t  new_ent, host_src, pix_nx, cur_nx;

   assign new_ent = '{r: stage_r, g: stage_g, b: wdata};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_r <= '0;
         stage_g <= '0;
      end else if (dat_wr) begin
         if (phase == PH_RED) stage_r <= wdata;
         if (phase == PH_GRN) stage_g <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (commit && !cur_mode)
         tbl[wr_ptr] <= new_ent;
   end

   for (genvar i = 0; i < CUR_N; i++) begin : g_cur
      always_ff @(posedge clk) begin
         if (!rst_n)
            cur_tbl[i] <= '0;
         else if (commit && cur_mode && (wr_ptr[CUR_W-1:0] == CUR_W'(i)))
            cur_tbl[i] <= new_ent;
      end
   end

   assign host_src = cur_mode ? cur_tbl[rd_ptr[CUR_W-1:0]] : tbl[rd_ptr];

   always_comb begin
      case (phase)
         PH_RED:  host_byte = host_src.r;
         PH_GRN:  host_byte = host_src.g;
         default: host_byte = host_src.b;
      endcase
   end

   assign pix_nx = tbl[look_idx];
   assign cur_nx = cur_tbl[cur_pick];

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pix_rgb <= '0;
            cur_rgb <= '0;
         end else begin
            pix_rgb <= pix_nx;
            cur_rgb <= cur_nx;
         end
      end
   end else begin : g_comb_out
      assign pix_rgb = pix_nx;
      assign cur_rgb = cur_nx;
   end
endmodule

// File: rtl/pal_dac_port.sv
module pal_dac_port
   import pal_dac_pkg::*;
#(
   parameter int IDX_W   = 8,
   parameter int CUR_N   = 2,
   parameter int CUR_W   = $clog2(CUR_N),
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cur_mode,
   input  logic             host_wr,
   input  logic             host_rd,
   input  logic [1:0]       host_addr,
   input  logic [7:0]       host_wdata,
   output logic [7:0]       host_rdata,
   input  logic [IDX_W-1:0] pix_idx,
   output logic [23:0]      pix_rgb,
   input  logic [CUR_W-1:0] cur_pick,
   output logic [23:0]      cur_rgb,
   output logic [7:0]       dac_ctl
);
   if (IDX_W < 1 || IDX_W > COMP_W) begin : g_bad_idx
      $error("pal_dac_port: IDX_W must lie in 1..COMP_W");
   end
   if (CUR_N < 2 || (1 << CUR_W) != CUR_N || CUR_W > IDX_W) begin : g_bad_cur
      $error("pal_dac_port: CUR_N must be a power of two, at least 2");
   end

   logic             rd_go, ld_widx, ld_ridx, dat_wr, dat_rd, mc_wr;
   phase_e           seq_phase;
   logic [IDX_W-1:0] seq_wr_ptr, seq_rd_ptr, look_idx;
   logic             seq_commit;
   comp_t            host_byte, mask_q, cmd_q;
   logic [7:0]       rd_mux;
   rgb_t             pix_s, cur_s;

   assign rd_go   = host_rd & ~host_wr;
   assign ld_widx = host_wr & (host_addr == A_WIDX);
   assign ld_ridx = host_wr & (host_addr == A_RIDX);
   assign dat_wr  = host_wr & (host_addr == A_DATA);
   assign dat_rd  = rd_go   & (host_addr == A_DATA);
   assign mc_wr   = host_wr & (host_addr == A_MASKCMD);

   pal_dac_seq #(.IDX_W(IDX_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode),
      .ld_widx(ld_widx), .ld_ridx(ld_ridx),
      .dat_wr(dat_wr), .dat_rd(dat_rd),
      .ld_val(host_wdata[IDX_W-1:0]),
      .phase(seq_phase), .wr_ptr(seq_wr_ptr), .rd_ptr(seq_rd_ptr),
      .commit(seq_commit)
   );

   assign look_idx = pix_idx & mask_q[IDX_W-1:0];

   pal_dac_store #(.IDX_W(IDX_W), .CUR_N(CUR_N), .CUR_W(CUR_W), .REG_OUT(REG_OUT)) store_i (
      .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode),
      .dat_wr(dat_wr), .commit(seq_commit), .phase(seq_phase),
      .wdata(host_wdata), .wr_ptr(seq_wr_ptr), .rd_ptr(seq_rd_ptr),
      .look_idx(look_idx), .cur_pick(cur_pick),
      .host_byte(host_byte), .pix_rgb(pix_s), .cur_rgb(cur_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '1;
         cmd_q  <= '0;
      end else if (mc_wr) begin
         if (cur_mode) cmd_q  <= host_wdata;
         else          mask_q <= host_wdata;
      end
   end

   always_comb begin
      case (host_addr)
         A_MASKCMD: rd_mux = cur_mode ? cmd_q : mask_q;
         A_RIDX:    rd_mux = 8'(seq_rd_ptr);
         A_WIDX:    rd_mux = 8'(seq_wr_ptr);
         default:   rd_mux = host_byte;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         host_rdata <= '0;
      else if (rd_go)
         host_rdata <= rd_mux;
   end

   assign pix_rgb = pix_s;
   assign cur_rgb = cur_s;
   assign dac_ctl = cmd_q;
endmodule

// File: rtl/pal_dac_chk.sv
module pal_dac_chk
   import pal_dac_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cur_mode,
   input logic             host_wr,
   input logic             host_rd,
   input logic [1:0]       host_addr,
   input logic [1:0]       phase,
   input logic [IDX_W-1:0] wr_ptr,
   input logic [IDX_W-1:0] rd_ptr,
   input logic [7:0]       mask_q
);
   logic dw, dr, ldx;
   assign dw  = host_wr && (host_addr == A_DATA);
   assign dr  = host_rd && !host_wr && (host_addr == A_DATA);
   assign ldx = host_wr && (host_addr == A_WIDX || host_addr == A_RIDX);

   AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      phase != 2'd3); // R3
   AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      ldx |=> phase == 2'd0); // R2
   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (dw || dr) |=> phase == (($past(phase) == 2'd2) ? 2'd0 : $past(phase) + 2'd1)); // R3
   AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (dw && phase == 2'd2 && !cur_mode) |=> wr_ptr == IDX_W'($past(wr_ptr) + 1'b1)); // R4
   AST_RPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (dr && phase == 2'd2 && !cur_mode) |=> rd_ptr == IDX_W'($past(rd_ptr) + 1'b1)); // R5
   AST_CUR_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ((dw || dr) && cur_mode) |=> ($stable(wr_ptr) && $stable(rd_ptr))); // R7
   AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_wr && host_addr == A_MASKCMD && !cur_mode) |=> $stable(mask_q)); // R8
endmodule

bind pal_dac_port pal_dac_chk #(.IDX_W(IDX_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode),
   .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
   .phase(seq_phase), .wr_ptr(seq_wr_ptr), .rd_ptr(seq_rd_ptr),
   .mask_q(mask_q)
);

// File: tb/pal_dac_port_tb_top.sv
`timescale 1ns/1ps
module pal_dac_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cur_mode = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [1:0]  host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic [7:0]  pix_idx = '0;
   logic [23:0] pix_rgb, cur_rgb;
   logic [0:0]  cur_pick = '0;
   logic [7:0]  dac_ctl;

   int checks = 0, failures = 0;
   logic lk_strobe = 1'b0, req_seen = 1'b0;

   typedef struct {
      int          kind;
      logic [23:0] val;
      string       req;
   } exp_t;
   exp_t exp_q[$];

   always #10 clk = ~clk;

   pal_dac_port dut_i (
      .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode),
      .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .pix_idx(pix_idx), .pix_rgb(pix_rgb),
      .cur_pick(cur_pick), .cur_rgb(cur_rgb), .dac_ctl(dac_ctl)
   );

   task automatic chk(input logic [23:0] act, input logic [23:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   always @(posedge clk) req_seen <= host_rd | lk_strobe;

   // monitor: pops one expected item per request cycle
   always @(negedge clk) begin
      exp_t        e;
      logic [23:0] act;
      if (req_seen && rst_n) begin
         if (exp_q.size() == 0) begin
            checks++;
            failures++;
            $display("FAIL scoreboard: result with no expected item, actual %h expected none", pix_rgb);
         end else begin
            e = exp_q.pop_front();
            case (e.kind)
               0:       act = {16'h0, host_rdata};
               1:       act = pix_rgb;
               default: act = cur_rgb;
            endcase
            chk(act, e.val, e.req);
         end
      end
   end

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(posedge clk); #1;
      host_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      host_rd = 1'b1; host_addr = a;
      exp_q.push_back('{0, {16'h0, exp}, req});
      @(posedge clk); #1;
      host_rd = 1'b0;
   endtask

   task automatic look(input logic [7:0] idx, input logic [23:0] exp, input string req);
      @(negedge clk);
      pix_idx = idx; lk_strobe = 1'b1;
      exp_q.push_back('{1, exp, req});
      @(posedge clk); #1;
      lk_strobe = 1'b0;
   endtask

   task automatic look_cur(input logic pick, input logic [23:0] exp, input string req);
      @(negedge clk);
      cur_pick = pick; lk_strobe = 1'b1;
      exp_q.push_back('{2, exp, req});
      @(posedge clk); #1;
      lk_strobe = 1'b0;
   endtask

   task automatic put_rgb(input logic [23:0] c);
      bus_wr(2'd3, c[23:16]);
      bus_wr(2'd3, c[15:8]);
      bus_wr(2'd3, c[7:0]);
   endtask

   task automatic get_rgb(input logic [23:0] c, input string req);
      bus_rd(2'd3, c[23:16], req);
      bus_rd(2'd3, c[15:8], req);
      bus_rd(2'd3, c[7:0], req);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1 reset state
      chk({16'h0, host_rdata}, 24'h0, "R1 host_rdata");
      chk(pix_rgb, 24'h0, "R1 pix_rgb");
      chk(cur_rgb, 24'h0, "R1 cur_rgb");
      chk({16'h0, dac_ctl}, 24'h0, "R1 dac_ctl");
      bus_rd(2'd0, 8'hFF, "R1 mask reset");
      bus_rd(2'd1, 8'h00, "R1 read pointer reset");
      bus_rd(2'd2, 8'h00, "R1 write pointer reset");

      // R3 store on blue only
      bus_wr(2'd2, 8'h05);
      put_rgb(24'h102030);
      look(8'h05, 24'h102030, "R3 full triple");
      bus_wr(2'd2, 8'h05);
      bus_wr(2'd3, 8'hAA);
      bus_wr(2'd3, 8'hBB);
      look(8'h05, 24'h102030, "R3 no commit before blue");
      bus_wr(2'd3, 8'hCC);
      look(8'h05, 24'hAABBCC, "R3 commit on blue");

      // R4 increment and wrap
      bus_rd(2'd2, 8'h06, "R4 write pointer advanced");
      put_rgb(24'h010203);
      look(8'h06, 24'h010203, "R4 next entry");
      bus_wr(2'd2, 8'hFF);
      put_rgb(24'hF1F2F3);
      put_rgb(24'h0A0B0C);
      look(8'hFF, 24'hF1F2F3, "R4 last entry");
      look(8'h00, 24'h0A0B0C, "R4 wrap to 0");
      bus_rd(2'd2, 8'h01, "R4 pointer after wrap");

      // R5 read triples
      bus_wr(2'd1, 8'h05);
      get_rgb(24'hAABBCC, "R5 read entry 5");
      get_rgb(24'h010203, "R5 read entry 6");
      bus_rd(2'd1, 8'h07, "R5 read pointer advanced");

      // R2 pointer load restarts phase
      bus_wr(2'd2, 8'h10);
      bus_wr(2'd3, 8'h77);
      bus_wr(2'd2, 8'h10);
      put_rgb(24'h445566);
      look(8'h10, 24'h445566, "R2 write phase restart");
      bus_wr(2'd1, 8'h05);
      bus_rd(2'd3, 8'hAA, "R2 red of entry 5");
      bus_wr(2'd1, 8'h06);
      get_rgb(24'h010203, "R2 read phase restart");

      // R6 / R7 cursor palette
      @(negedge clk) cur_mode = 1'b1;
      bus_wr(2'd2, 8'h01);
      put_rgb(24'hC1C2C3);
      look_cur(1'b1, 24'hC1C2C3, "R6 cursor colour 1");
      bus_rd(2'd2, 8'h01, "R7 write pointer held");
      bus_wr(2'd2, 8'h00);
      put_rgb(24'hD1D2D3);
      look_cur(1'b0, 24'hD1D2D3, "R6 cursor colour 0");
      look(8'h00, 24'h0A0B0C, "R6 main table untouched");
      put_rgb(24'hE1E2E3);
      look_cur(1'b0, 24'hE1E2E3, "R7 second triple same colour");
      look_cur(1'b1, 24'hC1C2C3, "R7 colour 1 untouched");
      bus_wr(2'd1, 8'h01);
      get_rgb(24'hC1C2C3, "R6 cursor read");
      get_rgb(24'hC1C2C3, "R7 cursor read no increment");

      // R8 alias, R9 mask
      bus_wr(2'd0, 8'h5A);
      bus_rd(2'd0, 8'h5A, "R8 command readback");
      @(negedge clk) chk({16'h0, dac_ctl}, 24'h00005A, "R8 dac_ctl");
      look(8'h05, 24'hAABBCC, "R8 mask not written in cursor mode");
      @(negedge clk) cur_mode = 1'b0;
      bus_rd(2'd0, 8'hFF, "R8 mask readback");
      bus_wr(2'd0, 8'h0F);
      look(8'h15, 24'hAABBCC, "R9 masked index 15");
      look(8'hF6, 24'h010203, "R9 masked index F6");
      @(negedge clk) chk({16'h0, dac_ctl}, 24'h00005A, "R8 command kept");
      @(negedge clk) cur_mode = 1'b1;
      bus_rd(2'd0, 8'h5A, "R8 command after mask write");

      repeat (3) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         failures++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule